// File: doc/BRIEF.md
# Transmit Priority Scheduler with Remote-Request Handling

This block chooses which message buffer the CAN transmit engine sends next. Every buffer configured for transmit and marked ready competes. Its 4-bit priority level is the major key and its index is the minor key, so 15 buffers at 16 levels give 240 distinct effective priorities. When the engine is idle and a candidate exists, the block latches the winner and raises a one-cycle start strobe. The choice then stays frozen until the engine reports either completion or lost arbitration.

The block also drives the status updates around remote frames. If a received remote request matches a transmit buffer that holds a data frame, that buffer is flagged ready. When a buffer that carried a remote request completes, it is told to turn into a receiver. A successful transmission clears the buffer's ready flag and, if that buffer's interrupt enable is set, pulses its interrupt line. The buffer status itself is stored outside the block. The block only reads it and emits the update pulses, which the buffer storage applies on the next clock edge.

Top module: `tx_prio_sched`

## Requirements
- R1: After reset, `start_o` and `sel_valid_o` are 0.
- R2: Only a buffer with both `buf_is_tx_i[i]` and `buf_rdy_i[i]` set is a candidate. With no candidate, no start is issued.
- R3: Among the candidates, the buffer with the largest priority value in `buf_prio_i[4*i+3:4*i]` wins. Value 15 is the highest.
- R4: When candidates share the top priority value, the lowest index wins.
- R5: If `eng_idle_i` is 1 at a clock edge, no frame is held and a candidate exists, then after that edge `start_o` is 1 for exactly one cycle. At the same time `sel_valid_o` rises and `sel_idx_o` shows the winner. `sel_valid_o` stays 1 until an edge at which `tx_done_i` or `arb_lost_i` is 1.
- R6: While `sel_valid_o` is 1, `sel_idx_o` does not change, whatever the buffer inputs do.
- R7: In a cycle where `tx_done_i` is 1 and a frame is held, `clr_ready_o` is one-hot on `sel_idx_o`. In every other cycle it is all zero.
- R8: On `arb_lost_i`, no ready flag is cleared. The buffer stays pending and the winner is recomputed from the current inputs at the next idle edge.
- R9: When `rx_rtr_vld_i` is 1, `set_ready_o` is one-hot on `rx_rtr_idx_i` if that index is below 15, the buffer is a transmit buffer, and its `buf_rtr_i` bit is 0. Otherwise `set_ready_o` is all zero.
- R10: On completion of a buffer whose `buf_rtr_i` bit is 1, `to_rx_o` is one-hot on that buffer in the same cycle.
- R11: On completion, `tx_irq_o` is one-hot on the sent buffer if its `irq_en_i` bit is 1, and all zero otherwise.
- R12: If a matching remote request names the buffer that completes in the same cycle, `set_ready_o` fires for it and `clr_ready_o` stays zero, so the reply is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| buf_is_tx_i | input | 15 | Buffer configured for transmit |
| buf_rdy_i | input | 15 | Buffer has a frame pending |
| buf_rtr_i | input | 15 | Buffer holds a remote request frame |
| buf_prio_i | input | 60 | 4-bit priority per buffer, buffer i at bits 4i+3..4i |
| irq_en_i | input | 15 | Per-buffer transmit interrupt enable |
| eng_idle_i | input | 1 | Transmit engine can take a new frame |
| tx_done_i | input | 1 | Held frame sent successfully |
| arb_lost_i | input | 1 | Held frame lost bus arbitration |
| rx_rtr_vld_i | input | 1 | Received remote request matched a buffer |
| rx_rtr_idx_i | input | 4 | Index of the matched buffer |
| sel_idx_o | output | 4 | Selected buffer |
| sel_valid_o | output | 1 | A frame is held for the engine |
| start_o | output | 1 | One-cycle start request |
| set_ready_o | output | 15 | Mark buffer ready |
| clr_ready_o | output | 15 | Clear buffer ready |
| to_rx_o | output | 15 | Reconfigure buffer as receiver |
| tx_irq_o | output | 15 | Transmit interrupt pulse per buffer |

## Verification
A completion and a remote-request match can land on the same buffer in the same cycle. In that case one path wants to clear the ready flag and the other wants to set it. The bench provokes this on every fourth trial by asserting `rx_rtr_vld_i` with the held index while `tx_done_i` is high. It expects `set_ready_o` to fire and `clr_ready_o` to stay zero, while the interrupt and receive-switch pulses behave as for a plain completion. Lost arbitration and re-selection are also interleaved with priority changes made while a frame is held. This checks that the freeze and the fresh recomputation do not interfere.

// File: rtl/tx_prio_sched_pkg.sv
package tx_prio_sched_pkg;
  typedef enum logic {
    ST_FREE = 1'b0,
    ST_HELD = 1'b1
  } sched_st_e;
endpackage

// File: rtl/tx_prio_sched_arb.sv
module tx_prio_sched_arb #(
  parameter int unsigned NUM_BUF = 15,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [NUM_BUF-1:0]        elig_i,
  input  logic [NUM_BUF*PRIO_W-1:0] prio_i,
  output logic                      vld_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare keeps the lower index on ties
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < int'(NUM_BUF); i++) begin
      if (elig_i[i] && (!vld_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/tx_prio_sched_ctrl.sv
module tx_prio_sched_ctrl #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_vld_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             eng_idle_i,
  input  logic             tx_done_i,
  input  logic             arb_lost_i,
  output logic             held_o,
  output logic             start_o,
  output logic [IDX_W-1:0] sel_o
);
  import tx_prio_sched_pkg::*;

  sched_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_FREE;
      start_o <= 1'b0;
      sel_o   <= '0;
    end else begin
      start_o <= 1'b0;
      case (st_q)
        ST_FREE: if (eng_idle_i && win_vld_i) begin
          st_q    <= ST_HELD;
          start_o <= 1'b1;
          sel_o   <= win_idx_i;
        end
        ST_HELD: if (tx_done_i || arb_lost_i) st_q <= ST_FREE;
        default: st_q <= ST_FREE;
      endcase
    end
  end

  assign held_o = (st_q == ST_HELD);
endmodule

// File: rtl/tx_prio_sched_upd.sv
module tx_prio_sched_upd #(
  parameter int unsigned NUM_BUF = 15,
  parameter int unsigned IDX_W   = 4
) (
  input  logic               done_hit_i,
  input  logic [IDX_W-1:0]   sel_i,
  input  logic               rx_vld_i,
  input  logic [IDX_W-1:0]   rx_idx_i,
  input  logic [NUM_BUF-1:0] is_tx_i,
  input  logic [NUM_BUF-1:0] rtr_i,
  input  logic [NUM_BUF-1:0] irq_en_i,
  output logic [NUM_BUF-1:0] set_o,
  output logic [NUM_BUF-1:0] clr_o,
  output logic [NUM_BUF-1:0] to_rx_o,
  output logic [NUM_BUF-1:0] irq_o
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic done_b, rx_b;
    assign done_b     = done_hit_i && (sel_i == IDX_W'(i));
    assign rx_b       = rx_vld_i && (rx_idx_i == IDX_W'(i)) && is_tx_i[i] && !rtr_i[i];
    assign set_o[i]   = rx_b;
    // a fresh remote request on the finishing buffer keeps it pending
    assign clr_o[i]   = done_b && !rx_b;
    assign to_rx_o[i] = done_b && rtr_i[i];
    assign irq_o[i]   = done_b && irq_en_i[i];
  end
endmodule

// File: rtl/tx_prio_sched.sv
module tx_prio_sched #(
  parameter int unsigned NUM_BUF = 15,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_BUF + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BUF-1:0]        buf_is_tx_i,
  input  logic [NUM_BUF-1:0]        buf_rdy_i,
  input  logic [NUM_BUF-1:0]        buf_rtr_i,
  input  logic [NUM_BUF*PRIO_W-1:0] buf_prio_i,
  input  logic [NUM_BUF-1:0]        irq_en_i,
  input  logic                      eng_idle_i,
  input  logic                      tx_done_i,
  input  logic                      arb_lost_i,
  input  logic                      rx_rtr_vld_i,
  input  logic [IDX_W-1:0]          rx_rtr_idx_i,
  output logic [IDX_W-1:0]          sel_idx_o,
  output logic                      sel_valid_o,
  output logic                      start_o,
  output logic [NUM_BUF-1:0]        set_ready_o,
  output logic [NUM_BUF-1:0]        clr_ready_o,
  output logic [NUM_BUF-1:0]        to_rx_o,
  output logic [NUM_BUF-1:0]        tx_irq_o
);
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic             held;

  tx_prio_sched_arb #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .elig_i (buf_is_tx_i & buf_rdy_i),
    .prio_i (buf_prio_i),
    .vld_o  (win_vld),
    .idx_o  (win_idx)
  );

  tx_prio_sched_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_vld_i  (win_vld),
    .win_idx_i  (win_idx),
    .eng_idle_i (eng_idle_i),
    .tx_done_i  (tx_done_i),
    .arb_lost_i (arb_lost_i),
    .held_o     (held),
    .start_o    (start_o),
    .sel_o      (sel_idx_o)
  );

  tx_prio_sched_upd #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_upd (
    .done_hit_i (tx_done_i && held),
    .sel_i      (sel_idx_o),
    .rx_vld_i   (rx_rtr_vld_i),
    .rx_idx_i   (rx_rtr_idx_i),
    .is_tx_i    (buf_is_tx_i),
    .rtr_i      (buf_rtr_i),
    .irq_en_i   (irq_en_i),
    .set_o      (set_ready_o),
    .clr_o      (clr_ready_o),
    .to_rx_o    (to_rx_o),
    .irq_o      (tx_irq_o)
  );

  assign sel_valid_o = held;
endmodule

// File: rtl/tx_prio_sched_chk.sv
module tx_prio_sched_chk #(
  parameter int unsigned NUM_BUF = 15,
  parameter int unsigned IDX_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_BUF-1:0] buf_is_tx_i,
  input logic [NUM_BUF-1:0] buf_rdy_i,
  input logic               eng_idle_i,
  input logic               tx_done_i,
  input logic               arb_lost_i,
  input logic               rx_rtr_vld_i,
  input logic [IDX_W-1:0]   sel_idx_o,
  input logic               sel_valid_o,
  input logic               start_o,
  input logic [NUM_BUF-1:0] set_ready_o,
  input logic [NUM_BUF-1:0] clr_ready_o,
  input logic [NUM_BUF-1:0] tx_irq_o
);
  localparam int unsigned EW = 1 << IDX_W;
  logic [EW-1:0] elig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_q <= '0;
    else         elig_q <= EW'(buf_is_tx_i & buf_rdy_i);
  end

  // R5
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R5
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(eng_idle_i));
  // R5
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o && (tx_done_i || arb_lost_i) |=> !sel_valid_o);
  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o && !start_o |-> $stable(sel_idx_o));
  // R2
  start_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> elig_q[sel_idx_o]);
  // R7
  clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_ready_o));
  // R8
  lost_noclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i && !tx_done_i |-> clr_ready_o == '0);
  // R9
  set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_ready_o) |-> rx_rtr_vld_i);
  // R11
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_irq_o) |-> (tx_done_i && sel_valid_o));
endmodule

bind tx_prio_sched tx_prio_sched_chk #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .buf_is_tx_i  (buf_is_tx_i),
  .buf_rdy_i    (buf_rdy_i),
  .eng_idle_i   (eng_idle_i),
  .tx_done_i    (tx_done_i),
  .arb_lost_i   (arb_lost_i),
  .rx_rtr_vld_i (rx_rtr_vld_i),
  .sel_idx_o    (sel_idx_o),
  .sel_valid_o  (sel_valid_o),
  .start_o      (start_o),
  .set_ready_o  (set_ready_o),
  .clr_ready_o  (clr_ready_o),
  .tx_irq_o     (tx_irq_o)
);

// File: tb/tx_prio_sched_bench.sv
module tx_prio_sched_bench;
  localparam int NB = 15;
  localparam int PW = 4;
  localparam int IW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NB-1:0]  is_tx = '0, rdy = '0, rtr = '0, irq_en = '0;
  logic [NB*PW-1:0] prio = '0;
  logic           idle = 1'b0, done = 1'b0, lost = 1'b0, rx_vld = 1'b0;
  logic [IW-1:0]  rx_idx = '0;
  logic [IW-1:0]  sel_idx;
  logic           sel_valid, start;
  logic [NB-1:0]  set_rdy, clr_rdy, to_rx, irq;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  tx_prio_sched u_tx_prio_sched (
    .clk_i(clk), .rst_ni(rst_n), .buf_is_tx_i(is_tx), .buf_rdy_i(rdy),
    .buf_rtr_i(rtr), .buf_prio_i(prio), .irq_en_i(irq_en), .eng_idle_i(idle),
    .tx_done_i(done), .arb_lost_i(lost), .rx_rtr_vld_i(rx_vld),
    .rx_rtr_idx_i(rx_idx), .sel_idx_o(sel_idx), .sel_valid_o(sel_valid),
    .start_o(start), .set_ready_o(set_rdy), .clr_ready_o(clr_rdy),
    .to_rx_o(to_rx), .tx_irq_o(irq)
  );

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // effective key: level * 16 + (15 - index); larger wins
  function automatic int exp_win();
    int bk = -1, bi = -1;
    for (int i = 0; i < NB; i++) begin
      if (is_tx[i] && rdy[i]) begin
        int k = int'(prio[i*PW +: PW]) * 16 + (15 - i);
        if (k > bk) begin bk = k; bi = i; end
      end
    end
    return bi;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    #1;
    chk(start == 1'b0 && sel_valid == 1'b0, "R1", {start, sel_valid}, 0);
    #10 rst_n = 1'b1;
    @(negedge clk);
    chk(start == 1'b0 && sel_valid == 1'b0, "R1", {start, sel_valid}, 0);

    for (int t = 0; t < 400; t++) begin
      int w;
      bit tie;
      @(negedge clk);
      is_tx  = NB'(rnd()) | NB'(1 << (t % NB));
      rdy    = (t % 8 == 0) ? '0 : NB'(rnd());
      rtr    = (t % 3 == 0) ? NB'(rnd()) : '0;
      irq_en = NB'(rnd());
      tie    = (t % 5 == 0);
      for (int i = 0; i < NB; i++)
        prio[i*PW +: PW] = tie ? PW'(t / 5) : PW'(rnd());
      idle = 1'b1;
      w = exp_win();
      @(posedge clk); #1;
      idle = 1'b0;
      if (w < 0) begin
        chk(start == 1'b0 && sel_valid == 1'b0, "R2", {start, sel_valid}, 0);
        continue;
      end
      chk(start == 1'b1, "R5", start, 1);
      chk(sel_idx == IW'(w), tie ? "R4" : "R3", sel_idx, w);

      // disturb inputs while held
      for (int i = 0; i < NB; i++) prio[i*PW +: PW] = PW'(rnd());
      rdy = rdy | NB'(rnd());
      @(posedge clk); #1;
      chk(start == 1'b0 && sel_valid == 1'b1 && sel_idx == IW'(w), "R6",
          {start, sel_valid, sel_idx}, {1'b0, 1'b1, IW'(w)});

      if (t % 2 == 1) begin
        lost = 1'b1;
        #1;
        chk(clr_rdy == '0 && irq == '0, "R8", clr_rdy, 0);
        @(posedge clk); #1;
        lost = 1'b0;
        chk(sel_valid == 1'b0, "R8", sel_valid, 0);
        idle = 1'b1;
        w = exp_win();
        @(posedge clk); #1;
        idle = 1'b0;
        chk(start == 1'b1 && sel_idx == IW'(w), "R8", {start, sel_idx}, {1'b1, IW'(w)});
      end

      begin
        bit col;
        logic [NB-1:0] oh;
        oh  = NB'(1) << w;
        col = (t % 4 == 0) && !rtr[w] && is_tx[w];
        done = 1'b1;
        if (col) begin rx_vld = 1'b1; rx_idx = IW'(w); end
        #1;
        chk(clr_rdy == (col ? '0 : oh), col ? "R12" : "R7", clr_rdy, col ? 0 : oh);
        chk(set_rdy == (col ? oh : '0), col ? "R12" : "R9", set_rdy, col ? oh : 0);
        chk(to_rx == (rtr[w] ? oh : '0), "R10", to_rx, rtr[w] ? oh : 0);
        chk(irq == (irq_en[w] ? oh : '0), "R11", irq, irq_en[w] ? oh : 0);
        @(posedge clk); #1;
        done = 1'b0;
        rx_vld = 1'b0;
        chk(sel_valid == 1'b0, "R5", sel_valid, 0);
      end

      // remote request match outside a completion
      begin
        int ri;
        logic [NB-1:0] ex;
        ri = int'(rnd() % 16);
        rx_idx = IW'(ri);
        rx_vld = 1'b1;
        #1;
        ex = (ri < NB && is_tx[ri] && !rtr[ri]) ? NB'(1) << ri : '0;
        chk(set_rdy == ex && clr_rdy == '0, "R9", set_rdy, ex);
        rx_vld = 1'b0;
      end
    end
    finish_run();
  end
endmodule